// File: doc/BRIEF.md
# Mains-Synchronized Reactor Firing Delay

This block times the gating of a thyristor-controlled reactor branch from the line voltage. A zero-crossing detector supplies a square wave that is in phase with the line voltage. The block recognises both edges of that wave. After each edge it waits a quarter of a mains cycle so that it reaches the voltage peak. It then counts down an 8-bit firing code and emits one firing strobe. This gives one strobe per half-cycle.

Timing uses a single-cycle enable, `tick`, that occurs 1024 times per mains cycle. A quarter cycle is therefore 256 ticks. A code of 0 fires exactly at the peak, which gives full reactor conduction. A code of 255 fires one tick before the next zero crossing, which gives practically no conduction.

Each strobe also starts a short burst of gate pulses on a separate output, so that the valve is fired reliably.

Top module: `reactor_fire_timer`

## Requirements
- R1: After the synchronous reset, `fire_strobe` and `gate_burst` are low. No strobe is issued until `sync_in` has changed level after reset. The level `sync_in` holds during reset is not an edge.
- R2: Rising and falling edges of `sync_in` both start a half-cycle. `sync_in` passes a two-stage synchronizer. The first tick counted is the first one sampled at least three clock edges after `sync_in` changes.
- R3: With code c sampled at the peak, `fire_strobe` is high in the clock cycle after the (256 + c)-th counted tick. A code of 0 therefore fires at the peak tick itself (tick 256).
- R4: A code of 255 fires at counted tick 511, one tick before the next zero crossing at tick 512.
- R5: `fire_code` is sampled only at the peak tick. A change before the peak is used. A change after the peak does not alter the pending strobe and takes effect from the next half-cycle.
- R6: `fire_strobe` lasts exactly one clock cycle and follows a tick. Exactly one strobe is issued per started half-cycle whose peak is reached.
- R7: Each strobe starts a burst on `gate_burst` of 8 pulses. Each pulse is 2 ticks high and 2 ticks low. The burst is high from the strobe cycle onward and lasts 32 ticks in total.
- R8: A strobe that arrives while a burst is running restarts the burst from its first pulse.
- R9: A `sync_in` edge that arrives while a delay countdown is pending restarts the quarter-cycle wait. It does not cancel the pending strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timing enable, 1024 pulses per mains cycle |
| sync_in | input | 1 | Square wave from the zero-crossing detector (asynchronous) |
| fire_code | input | 8 | Firing delay after the voltage peak, in ticks |
| fire_strobe | output | 1 | One-cycle firing strobe |
| gate_burst | output | 1 | Gate pulse train following each strobe |

## Verification
The bench builds the block with its default parameters: 8-bit code, 256-tick quarter wait, and a burst of 8 pulses of 2+2 ticks. It drives `tick` every fourth clock. With these settings both extreme codes (0 and 255) and the full quarter-cycle wait are reached within a few half-cycles. The burst is short compared with a half-cycle, so a burst restart is forced by a shortened half-cycle: a code-255 countdown is followed by an early edge with code 0. The same run shows that a new edge does not cancel a pending strobe.

// File: rtl/reactor_fire_timer.sv
module reactor_fire_timer #(
  parameter int CODE_W        = 8,
  parameter int QUARTER_TICKS = 256,
  parameter int PULSE_COUNT   = 8,
  parameter int HIGH_TICKS    = 2,
  parameter int LOW_TICKS     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sync_in,
  input  logic [CODE_W-1:0] fire_code,
  output logic              fire_strobe,
  output logic              gate_burst
);

  localparam int WAIT_W      = $clog2(QUARTER_TICKS + 1);
  localparam int PERIOD      = HIGH_TICKS + LOW_TICKS;
  localparam int BURST_TICKS = PULSE_COUNT * PERIOD;
  localparam int BURST_W     = $clog2(BURST_TICKS + 1);
  localparam int POS_W       = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  // input synchronizer and edge detect
  logic [1:0] sync_ff;
  logic       sync_prev;
  logic [1:0] warm;
  logic       sync_edge;

  always_ff @(posedge clk) begin
    sync_ff   <= {sync_ff[0], sync_in};
    sync_prev <= sync_ff[1];
    if (rst)                warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  assign sync_edge = (warm == 2'd3) && (sync_ff[1] ^ sync_prev);

  // quarter-cycle wait to the voltage peak
  logic              waiting;
  logic [WAIT_W-1:0] wait_cnt;
  logic              peak;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting  <= 1'b0;
      wait_cnt <= '0;
    end else if (sync_edge) begin
      waiting  <= 1'b1;
      wait_cnt <= WAIT_W'(QUARTER_TICKS);
    end else if (waiting && tick) begin
      if (wait_cnt == WAIT_W'(1)) waiting <= 1'b0;
      wait_cnt <= wait_cnt - WAIT_W'(1);
    end
  end

  assign peak = waiting && tick && !sync_edge && (wait_cnt == WAIT_W'(1));

  // delay countdown loaded at the peak
  logic              counting;
  logic [CODE_W-1:0] delay_cnt;
  logic              fire_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      counting  <= 1'b0;
      delay_cnt <= '0;
    end else if (peak) begin
      counting  <= (fire_code != '0);
      delay_cnt <= fire_code;
    end else if (counting && tick) begin
      if (delay_cnt == CODE_W'(1)) counting <= 1'b0;
      delay_cnt <= delay_cnt - CODE_W'(1);
    end
  end

  assign fire_now = peak ? (fire_code == '0)
                         : (counting && tick && delay_cnt == CODE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) fire_strobe <= 1'b0;
    else     fire_strobe <= fire_now;
  end

  // gate pulse train
  logic [BURST_W-1:0] burst_left;
  logic [POS_W-1:0]   pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_left <= '0;
      pos        <= '0;
    end else if (fire_now) begin
      burst_left <= BURST_W'(BURST_TICKS);
      pos        <= '0;
    end else if (tick && burst_left != '0) begin
      burst_left <= burst_left - BURST_W'(1);
      pos        <= (pos == POS_W'(PERIOD - 1)) ? '0 : pos + POS_W'(1);
    end
  end

  assign gate_burst = (burst_left != '0) && (pos < POS_W'(HIGH_TICKS));

  // R1
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd3) |-> (!waiting && !counting && !fire_strobe));

  // R2
  wait_range_chk: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= WAIT_W'(QUARTER_TICKS));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    fire_strobe |=> !fire_strobe);

  // R6
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    fire_strobe |-> $past(tick));

  // R7
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fire_strobe |-> gate_burst);

  // R7
  gate_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(gate_burst));

endmodule

// File: tb/test_reactor_fire_timer.sv
module test_reactor_fire_timer;

  localparam int QT = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick;
  logic       sync_in = 1'b1;
  logic [7:0] fire_code = 8'd0;
  logic       fire_strobe;
  logic       gate_burst;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int strobes_seen = 0;
  int strobes_exp = 0;
  int gate_err_main = 0;
  int gate_err_restart = 0;
  bit in_restart = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  int    gate_q[$];
  int    last_fire = 0;
  bit    have_fire = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick = (cyc % 4 == 0);

  reactor_fire_timer i_reactor_fire_timer (
    .clk(clk), .rst(rst), .tick(tick), .sync_in(sync_in),
    .fire_code(fire_code), .fire_strobe(fire_strobe), .gate_burst(gate_burst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic align();
    do @(negedge clk); while (cyc % 4 != 1);
  endtask

  task automatic wait_ticks(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic push_fire(input int at, input string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
    gate_q.push_back(at);
    strobes_exp++;
  endtask

  task automatic new_edge(input int code, output int p0);
    align();
    sync_in   = ~sync_in;
    fire_code = code[7:0];
    p0 = cyc;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (fire_strobe) begin
        strobes_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 R6 unexpected strobe", cyc, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cyc == e, t, cyc, e);
        end
      end
      while (gate_q.size() != 0 && gate_q[0] <= cyc) begin
        last_fire = gate_q.pop_front();
        have_fire = 1'b1;
      end
      begin
        int  d;
        bit  expg;
        d = cyc - last_fire;
        expg = have_fire && d < 128 && ((d / 4) % 4) < 2;
        if (gate_burst !== expg) begin
          if (in_restart) gate_err_restart++;
          else            gate_err_main++;
          if (gate_err_main + gate_err_restart <= 5)
            $display("gate mismatch at %0d: got %0b want %0b", cyc, gate_burst, expg);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0, p1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(fire_strobe == 1'b0, "R1 strobe in reset", fire_strobe, 0);
    chk(gate_burst == 1'b0, "R1 gate in reset", gate_burst, 0);
    rst = 1'b0;
    repeat (3000) @(negedge clk);
    chk(strobes_seen == 0, "R1 no strobe before first edge", strobes_seen, 0);
    chk(gate_burst == 1'b0, "R1 gate idle before first edge", gate_burst, 0);

    // R2 R3 both polarities, several codes
    new_edge(0, p0);   push_fire(p0 + 4 * (QT + 0), "R3 code 0 at peak (falling edge R2)");
    wait_ticks(512);
    new_edge(1, p0);   push_fire(p0 + 4 * (QT + 1), "R2 rising edge code 1");
    wait_ticks(512);
    new_edge(100, p0); push_fire(p0 + 4 * (QT + 100), "R3 code 100");
    wait_ticks(512);
    new_edge(255, p0); push_fire(p0 + 4 * (QT + 255), "R4 code 255");
    wait_ticks(512);
    new_edge(128, p0); push_fire(p0 + 4 * (QT + 128), "R3 code 128");
    wait_ticks(512);

    // R5 change before peak is used
    new_edge(10, p0);  push_fire(p0 + 4 * (QT + 40), "R5 change before peak");
    wait_ticks(100);
    fire_code = 8'd40;
    wait_ticks(412);
    // R5 change after peak is ignored this half-cycle
    new_edge(200, p0); push_fire(p0 + 4 * (QT + 200), "R5 change after peak ignored");
    wait_ticks(300);
    fire_code = 8'd5;
    wait_ticks(212);
    align();
    sync_in = ~sync_in;
    p0 = cyc;
    push_fire(p0 + 4 * (QT + 5), "R5 new code next half-cycle");
    wait_ticks(512);

    // R8 R9 early edge during countdown, burst restart
    in_restart = 1'b1;
    new_edge(255, p0); push_fire(p0 + 4 * (QT + 255), "R9 pending strobe kept");
    wait_ticks(260);
    new_edge(0, p1);   push_fire(p1 + 4 * QT, "R8 second strobe during burst");
    wait_ticks(300);
    in_restart = 1'b0;
    wait_ticks(212);

    repeat (200) @(negedge clk);
    chk(exp_q.size() == 0, "R3 missing strobes", exp_q.size(), 0);
    chk(strobes_seen == strobes_exp, "R6 one strobe per half-cycle", strobes_seen, strobes_exp);
    chk(gate_err_main == 0, "R7 burst waveform", gate_err_main, 0);
    chk(gate_err_restart == 0, "R8 burst restart waveform", gate_err_restart, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule